// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Limiter

This block produces the low-side enable for one phase group of a motor bridge. A free-running ramp counter counts clock cycles through a programmable period. The enable is high while the ramp value lies below a duty command, which gives a duty of `duty_cmd / period_cmd`. A comparator outside the block reports over-current on a single-bit flag. A qualified over-current starts a one-shot that blanks the enable for a programmed number of cycles, whatever the duty command asks for.

The one-shot is fixed-length. Further over-current reports inside the window do not stretch it. A report still present in the last cycle of the window reloads it, so the drive stays off with no gap. The turn-on edge of a power stage produces a short current spike, and this spike must not trip the limit. A leading-edge blanking count therefore masks the over-current flag for the first cycles of each on interval of the ramp comparison.

Top module: `ftoff_limiter`

## Requirements
- R1: While `rst_n` is low, `limit_act` is low and the ramp counter is held at zero. In the first cycle after release the counter is zero.
- R2: The ramp counter counts 0 up to `period_cmd`-1 and then returns to 0, so it repeats every `period_cmd` cycles. A period of 0 behaves as a period of 1.
- R3: When no limit is active, `ls_en` is high exactly in the cycles whose ramp value is below `duty_cmd`. Each period starts with its on part at ramp value 0.
- R4: A `duty_cmd` of 0 holds `ls_en` low. A `duty_cmd` equal to or above `period_cmd` holds it high when no limit is active.
- R5: A qualified `oc_in` in cycle t, with no limit active, makes `limit_act` high and `ls_en` low in cycles t+1 through t+N, where N is `off_len`. A value of 0 for `off_len` acts as 1.
- R6: An `oc_in` pulse during the off window, before its last cycle, does not change the window's length.
- R7: An `oc_in` that is present in the last cycle of the off window reloads the window for another N cycles. `ls_en` does not go high in between.
- R8: `oc_in` is ignored during the first `blank_len` cycles of each on interval of the ramp comparison. These are counted from the cycle in which the comparison first becomes true. A `blank_len` of 0 masks nothing. The end of an off window does not restart blanking.
- R9: `oc_in` is not masked while the ramp comparison is false, so over-current seen in the off part of a period also starts the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cmd | input | CNT_W | Ramp period in cycles |
| duty_cmd | input | CNT_W | On cycles per period |
| off_len | input | OFF_W | Off window length in cycles |
| blank_len | input | BLANK_W | Leading-edge blanking length in cycles |
| oc_in | input | 1 | Over-current flag, active high |
| ls_en | output | 1 | Gated low-side enable |
| limit_act | output | 1 | High while the off window runs |

## Verification
The bench targets the edges of the off window. It checks that the window lasts exactly N cycles, that a mid-window pulse does not extend it, and that a pulse held into the last cycle reloads it. A design with an off-by-one counter would shorten the window or leave a one-cycle on gap. A retrigger on any pulse would lengthen the window. The bench also places pulses inside and just beyond the blanking count. A wrong blanking design would either trip on the turn-on spike, or ignore a real fault right after an off window by restarting the mask. The duty extremes of 0, the period and above are checked as well, along with a period of 0, for designs that glitch at the ramp wrap.

// File: rtl/ftoff_pkg.sv
`timescale 1ns/1ps
package ftoff_pkg;
  // Phase of the off-time one-shot, decoded from its down-counter
  typedef enum logic [1:0] {
    OS_IDLE = 2'd0,
    OS_HOLD = 2'd1,
    OS_LAST = 2'd2
  } os_phase_e;
endpackage

// File: rtl/ftoff_ramp.sv
`timescale 1ns/1ps
module ftoff_ramp #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cmd,
  input  logic [CNT_W-1:0] duty_cmd,
  output logic             pwm_raw
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] cnt_inc;
  logic             wrap;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    wrap    = (cnt_inc >= {1'b0, period_cmd});
    cnt_d   = wrap ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pwm_raw = (cnt_q < duty_cmd);
endmodule

// File: rtl/ftoff_blank.sv
`timescale 1ns/1ps
module ftoff_blank #(
  parameter int unsigned BLANK_W  = 4,
  parameter bit          BLANK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_raw,
  input  logic [BLANK_W-1:0] blank_len,
  output logic               blank_act
);
  localparam logic [BLANK_W-1:0] AGE_MAX = '1;
  localparam logic [BLANK_W-1:0] AGE_ONE = {{(BLANK_W-1){1'b0}}, 1'b1};

  generate
    if (BLANK_EN) begin : g_blank
      logic [BLANK_W-1:0] age_q, age_d;
      logic               age_en;

      // age counts on-cycles since the comparator went true, saturating
      always_comb begin
        age_en = 1'b1;
        if (!pwm_raw)               age_d = '0;
        else if (age_q == AGE_MAX) begin
          age_d  = age_q;
          age_en = 1'b0;
        end
        else                        age_d = age_q + AGE_ONE;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      age_q <= '0;
        else if (age_en) age_q <= age_d;
      end

      assign blank_act = pwm_raw && (age_q < blank_len);
    end else begin : g_noblank
      assign blank_act = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ftoff_oneshot.sv
`timescale 1ns/1ps
module ftoff_oneshot
  import ftoff_pkg::*;
#(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [OFF_W-1:0] off_len,
  output logic             active
);
  localparam logic [OFF_W-1:0] OFF_ONE = {{(OFF_W-1){1'b0}}, 1'b1};

  logic [OFF_W-1:0] off_q, off_d, load_val;
  os_phase_e        phase;

  always_comb begin
    if (off_q == '0)          phase = OS_IDLE;
    else if (off_q == OFF_ONE) phase = OS_LAST;
    else                      phase = OS_HOLD;
  end

  always_comb begin
    load_val = (off_len == '0) ? OFF_ONE : off_len;
    unique case (phase)
      OS_IDLE: off_d = trig ? load_val : '0;
      OS_LAST: off_d = trig ? load_val : '0;
      default: off_d = off_q - OFF_ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  assign active = (phase != OS_IDLE);
endmodule

// File: rtl/ftoff_limiter.sv
`timescale 1ns/1ps
module ftoff_limiter #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned OFF_W    = 8,
  parameter int unsigned BLANK_W  = 4,
  parameter bit          BLANK_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   period_cmd,
  input  logic [CNT_W-1:0]   duty_cmd,
  input  logic [OFF_W-1:0]   off_len,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic               oc_in,
  output logic               ls_en,
  output logic               limit_act
);
  logic pwm_raw;
  logic blank_act;
  logic oc_qual;

  ftoff_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_cmd (period_cmd),
    .duty_cmd   (duty_cmd),
    .pwm_raw    (pwm_raw)
  );

  ftoff_blank #(.BLANK_W(BLANK_W), .BLANK_EN(BLANK_EN)) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_raw   (pwm_raw),
    .blank_len (blank_len),
    .blank_act (blank_act)
  );

  assign oc_qual = oc_in && !blank_act;

  ftoff_oneshot #(.OFF_W(OFF_W)) u_oneshot (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (oc_qual),
    .off_len (off_len),
    .active  (limit_act)
  );

  assign ls_en = pwm_raw && !limit_act;
endmodule

// File: rtl/ftoff_limiter_chk.sv
`timescale 1ns/1ps
module ftoff_limiter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] duty_cmd,
  input logic             oc_in,
  input logic             blank_act,
  input logic             ls_en,
  input logic             limit_act
);
  AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cmd == '0) |-> !ls_en); // R4

  AST_LIMIT_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    limit_act |-> !ls_en); // R5

  AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_in && !blank_act) |=> limit_act); // R5

  AST_RISE_NEEDS_OC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_act) |-> $past(oc_in)); // R5

  AST_BLANK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_act && !limit_act) |=> !limit_act); // R8
endmodule

bind ftoff_limiter ftoff_limiter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .duty_cmd  (duty_cmd),
  .oc_in     (oc_in),
  .blank_act (blank_act),
  .ls_en     (ls_en),
  .limit_act (limit_act)
);

// File: tb/ftoff_limiter_test.sv
`timescale 1ns/1ps
module ftoff_limiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int OFF_W = 8;
  localparam int BLANK_W = 4;

  logic               clk;
  logic               rst_n;
  logic [CNT_W-1:0]   period_cmd;
  logic [CNT_W-1:0]   duty_cmd;
  logic [OFF_W-1:0]   off_len;
  logic [BLANK_W-1:0] blank_len;
  logic               oc_in;
  logic               ls_en;
  logic               limit_act;

  ftoff_limiter #(.CNT_W(CNT_W), .OFF_W(OFF_W), .BLANK_W(BLANK_W)) uut (
    .clk(clk), .rst_n(rst_n), .period_cmd(period_cmd), .duty_cmd(duty_cmd),
    .off_len(off_len), .blank_len(blank_len), .oc_in(oc_in),
    .ls_en(ls_en), .limit_act(limit_act)
  );

  typedef struct {
    int    cyc;
    bit    ls;
    bit    lim;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   base = 0;
  int   checks = 0;
  int   errors = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations in the cycle they belong to
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc != cyc || ls_en !== it.ls || limit_act !== it.lim) begin
        errors++;
        $display("FAIL %s cycle %0d: ls_en=%b limit_act=%b expected ls_en=%b limit_act=%b",
                 it.tag, it.cyc - base, ls_en, limit_act, it.ls, it.lim);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic goto(int k);
    while (cyc < base + k) step();
  endtask

  task automatic expect_at(int k, bit ls, bit lim, string tag);
    q.push_back('{base + k, ls, lim, tag});
  endtask

  task automatic expect_span(int k0, int k1, bit ls, bit lim, string tag);
    for (int k = k0; k <= k1; k++) expect_at(k, ls, lim, tag);
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    base = cyc;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    period_cmd = '0; duty_cmd = '0; off_len = '0; blank_len = '0; oc_in = 1'b0;
    q.push_back('{1, 1'b0, 1'b0, "R1"});  // in reset, zero duty: all low
    step(); step();

    // R2/R3: period 10, duty 3
    period_cmd = 8'd10; duty_cmd = 8'd3; off_len = 8'd4; blank_len = 4'd2;
    do_reset();
    for (int k = 0; k < 20; k++)
      expect_at(k, (k % 10) < 3, 1'b0, (k == 9 || k == 10) ? "R2" : "R3");
    goto(20);
    period_cmd = 8'd0; duty_cmd = 8'd1;    // period 0 acts as 1
    expect_span(21, 25, 1'b1, 1'b0, "R2");
    goto(27);

    // R4: duty extremes
    period_cmd = 8'd10; duty_cmd = 8'd0;
    do_reset();
    expect_span(0, 24, 1'b0, 1'b0, "R4");
    goto(25);
    duty_cmd = 8'd10;
    expect_span(25, 49, 1'b1, 1'b0, "R4");
    goto(50);
    duty_cmd = 8'd255;
    expect_span(50, 59, 1'b1, 1'b0, "R4");
    goto(61);

    // R5/R6: single trigger, mid-window pulse ignored
    duty_cmd = 8'd10; blank_len = 4'd0; off_len = 8'd4;
    do_reset();
    expect_at(5, 1'b1, 1'b0, "R5");
    expect_span(6, 9, 1'b0, 1'b1, "R5");
    expect_at(10, 1'b1, 1'b0, "R6");
    goto(5); oc_in = 1'b1;
    goto(6); oc_in = 1'b0;
    goto(7); oc_in = 1'b1;
    goto(8); oc_in = 1'b0;
    goto(12);

    // R9: over-current during the off part of the period
    duty_cmd = 8'd3; blank_len = 4'd2;
    do_reset();
    expect_at(5, 1'b0, 1'b0, "R9");
    expect_span(6, 9, 1'b0, 1'b1, "R9");
    expect_at(10, 1'b1, 1'b0, "R9");
    goto(5); oc_in = 1'b1;
    goto(6); oc_in = 1'b0;
    goto(12);

    // R7: fault held into last off cycle reloads the window
    duty_cmd = 8'd10; blank_len = 4'd0;
    do_reset();
    expect_span(6, 13, 1'b0, 1'b1, "R7");
    expect_at(14, 1'b1, 1'b0, "R7");
    goto(5); oc_in = 1'b1;
    goto(10); oc_in = 1'b0;
    goto(16);

    // R5: off length 0 acts as 1
    off_len = 8'd0;
    do_reset();
    expect_at(6, 1'b0, 1'b1, "R5");
    expect_at(7, 1'b1, 1'b0, "R5");
    goto(5); oc_in = 1'b1;
    goto(6); oc_in = 1'b0;
    goto(9);

    // R8: leading-edge blanking, duty 5, blank 3
    off_len = 8'd4; duty_cmd = 8'd5; blank_len = 4'd3;
    do_reset();
    expect_span(12, 13, 1'b1, 1'b0, "R8");
    expect_span(14, 17, 1'b0, 1'b1, "R8");
    expect_at(18, 1'b0, 1'b0, "R8");
    expect_at(20, 1'b1, 1'b0, "R8");
    expect_span(21, 24, 1'b0, 1'b1, "R8");
    expect_at(25, 1'b0, 1'b0, "R8");
    goto(11); oc_in = 1'b1;               // ramp value 1: blanked
    goto(12); oc_in = 1'b0;
    goto(13); oc_in = 1'b1;               // ramp value 3: past the mask
    goto(14); oc_in = 1'b0;
    goto(19); blank_len = 4'd0;
    goto(20); oc_in = 1'b1;               // turn-on cycle, no mask
    goto(21); oc_in = 1'b0;
    goto(27);

    // R8: end of off window does not restart blanking
    duty_cmd = 8'd10; blank_len = 4'd3;
    do_reset();
    expect_span(6, 9, 1'b0, 1'b1, "R8");
    expect_at(10, 1'b1, 1'b0, "R8");
    expect_at(11, 1'b0, 1'b1, "R8");
    goto(5); oc_in = 1'b1;
    goto(6); oc_in = 1'b0;
    goto(10); oc_in = 1'b1;
    goto(11); oc_in = 1'b0;
    goto(16);

    // R1: reset clears an active limit
    blank_len = 4'd0;
    do_reset();
    expect_at(3, 1'b0, 1'b1, "R5");
    expect_at(4, 1'b1, 1'b0, "R1");
    goto(2); oc_in = 1'b1;
    goto(3); oc_in = 1'b0;
    goto(4); rst_n = 1'b0;
    goto(6); rst_n = 1'b1;
    step(); step();

    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    summary();
    $finish;
  end
endmodule